// File: doc/BRIEF.md
# Charge-Balance Rate-to-Count Converter

This block turns a signed velocity word into a stream of single-cycle count pulses for a downstream angle counter. It models an incremental integrator: every clock the velocity is added to a signed accumulator. On each rate-limit tick, the block checks the accumulator against a threshold quantum. If the accumulator is at or above the positive threshold, it issues one down pulse and subtracts one quantum. If it is at or below the negative threshold, it issues one up pulse and adds one quantum. The long-run pulse rate is therefore proportional to the velocity divided by the quantum, and its sign is opposite to the sign of the velocity.

A parameterised divider produces the tick, which caps the pulse rate at one pulse per `TICK_DIV` clocks. The accumulator keeps any charge the block could not yet discharge. It saturates at `SAT_MULT` quanta, so a sustained overdrive can neither wrap the register nor leave a large backlog behind.

Control is a three-state machine. `ST_INTEG` means integrating with no pulse out. `ST_UP` means an up pulse is being presented. `ST_DN` means a down pulse is being presented. From any state, a tick with the saturated sum at or above `+THRESH` moves to `ST_DN`. Failing that, a tick with the sum at or below `-THRESH` moves to `ST_UP`. Every other cycle moves to `ST_INTEG`. Reset forces `ST_INTEG`.

Top module: `rate_count_vco`

## Requirements
- R1: While `rst_n` is low, both pulse outputs stay 0, and releasing reset starts the block from an empty accumulator and a fresh divider.
- R2: Each clock, the two's-complement value of `vel_in` is added to the accumulator, so a constant velocity builds charge linearly in time.
- R3: On a tick where the saturated sum is greater than or equal to +`THRESH`, `cnt_dn` is issued and the accumulator takes the sum minus `THRESH` (a sum of exactly +`THRESH` fires).
- R4: On a tick where the saturated sum is less than or equal to -`THRESH`, `cnt_up` is issued and the accumulator takes the sum plus `THRESH` (a sum of exactly -`THRESH` fires).
- R5: A tick occurs on the `TICK_DIV`-th clock edge after reset release and every `TICK_DIV` edges after that. Pulses happen only on ticks, at most one per tick.
- R6: `cnt_up` and `cnt_dn` are never high in the same cycle.
- R7: The accumulator saturates at ±`SAT_MULT`·`THRESH`. With defaults and full-scale input, the pulse rate is exactly one per tick.
- R8: A pulse is registered. It is high for exactly one clock, in the cycle following the edge that decided it.
- R9: Charge left over when the rate cap binds is kept and discharged on later ticks, even after the input falls to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vel_in | input | VEL_W | Signed velocity word, two's complement |
| cnt_up | output | 1 | One-cycle up-count pulse |
| cnt_dn | output | 1 | One-cycle down-count pulse |

## Verification
The assertions assume that `rst_n` is low on the first clock edge, that `THRESH` is positive, and that `TICK_DIV` is at least 2, so that two ticks can never fall on adjacent edges. The bench applies reset at time zero and keeps the default parameters. It changes `vel_in` only on falling edges and holds it constant through each run. Every stimulus value stays inside the signed `VEL_W` range, including the most negative code.

// File: rtl/rcv_pkg.sv
`timescale 1ns/1ps
package rcv_pkg;
    typedef enum logic [1:0] {
        ST_INTEG = 2'd0,
        ST_UP    = 2'd1,
        ST_DN    = 2'd2
    } rcv_state_e;
endpackage

// File: rtl/rcv_tick_div.sv
`timescale 1ns/1ps
module rcv_tick_div #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    // ticks are spaced TICK_DIV edges apart, so two never fall on adjacent edges
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
endmodule

// File: rtl/rcv_accum.sv
`timescale 1ns/1ps
module rcv_accum #(
    parameter int VEL_W  = 12,
    parameter int THRESH = 1024,
    parameter int SAT    = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEL_W-1:0] vel,
    input  logic             take_up,
    input  logic             take_dn,
    output logic             sum_ge,
    output logic             sum_le
);
    localparam int SAT_BITS = $clog2(SAT + 1) + 1;
    localparam int ACC_W    = (SAT_BITS > VEL_W) ? SAT_BITS : VEL_W;
    localparam logic signed [ACC_W:0] TH_P  = (ACC_W+1)'(THRESH);
    localparam logic signed [ACC_W:0] TH_N  = -TH_P;
    localparam logic signed [ACC_W:0] SAT_P = (ACC_W+1)'(SAT);
    localparam logic signed [ACC_W:0] SAT_N = -SAT_P;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W:0]   vel_ext;
    logic signed [ACC_W:0]   sum_raw;
    logic signed [ACC_W:0]   sum_sat;
    logic signed [ACC_W:0]   acc_d;

    always_comb begin
        vel_ext = $signed({{(ACC_W+1-VEL_W){vel[VEL_W-1]}}, vel});
        sum_raw = $signed({acc_q[ACC_W-1], acc_q}) + vel_ext;
        if (sum_raw > SAT_P) begin
            sum_sat = SAT_P;
        end else if (sum_raw < SAT_N) begin
            sum_sat = SAT_N;
        end else begin
            sum_sat = sum_raw;
        end
    end

    assign sum_ge = (sum_sat >= TH_P);
    assign sum_le = (sum_sat <= TH_N);

    always_comb begin
        if (take_dn) begin
            acc_d = sum_sat - TH_P;
        end else if (take_up) begin
            acc_d = sum_sat + TH_P;
        end else begin
            acc_d = sum_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d[ACC_W-1:0];
        end
    end

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((ACC_W+1)'(acc_q) <= SAT_P) && ((ACC_W+1)'(acc_q) >= SAT_N)); // R7
    AST_DN_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        take_dn |=> ((ACC_W+1)'(acc_q) <= SAT_P - TH_P)); // R3
    AST_UP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        take_up |=> ((ACC_W+1)'(acc_q) >= SAT_N + TH_P)); // R4
endmodule

// File: rtl/rcv_ctrl.sv
`timescale 1ns/1ps
module rcv_ctrl
    import rcv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sum_ge,
    input  logic sum_le,
    output logic take_up,
    output logic take_dn,
    output logic cnt_up,
    output logic cnt_dn
);
    rcv_state_e st_q;
    rcv_state_e st_d;

    always_comb begin
        st_d = ST_INTEG;
        unique case (st_q)
            ST_INTEG, ST_UP, ST_DN: begin
                if (tick && sum_ge) begin
                    st_d = ST_DN;
                end else if (tick && sum_le) begin
                    st_d = ST_UP;
                end else begin
                    st_d = ST_INTEG;
                end
            end
            default: st_d = ST_INTEG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_INTEG;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        take_dn = (st_d == ST_DN);
        take_up = (st_d == ST_UP);
        cnt_dn  = (st_q == ST_DN);
        cnt_up  = (st_q == ST_UP);
    end

    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_up && cnt_dn)); // R6
    AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (take_up || take_dn) |-> tick); // R5
endmodule

// File: rtl/rate_count_vco.sv
`timescale 1ns/1ps
module rate_count_vco #(
    parameter int VEL_W    = 12,
    parameter int THRESH   = 1024,
    parameter int SAT_MULT = 4,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEL_W-1:0] vel_in,
    output logic             cnt_up,
    output logic             cnt_dn
);
    localparam int SAT = SAT_MULT * THRESH;

    logic tick;
    logic sum_ge;
    logic sum_le;
    logic take_up;
    logic take_dn;

    rcv_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rcv_accum #(.VEL_W(VEL_W), .THRESH(THRESH), .SAT(SAT)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .vel     (vel_in),
        .take_up (take_up),
        .take_dn (take_dn),
        .sum_ge  (sum_ge),
        .sum_le  (sum_le)
    );

    rcv_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .sum_ge  (sum_ge),
        .sum_le  (sum_le),
        .take_up (take_up),
        .take_dn (take_dn),
        .cnt_up  (cnt_up),
        .cnt_dn  (cnt_dn)
    );

    AST_DN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dn |=> !cnt_dn); // R8
    AST_UP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_up |=> !cnt_up); // R8
endmodule

// File: tb/rate_count_vco_bench.sv
`timescale 1ns/1ps
module rate_count_vco_bench;
    localparam int VEL_W = 12;
    localparam int DIV   = 4;
    localparam int NV    = 11;
    localparam int V_VEL [NV] = '{256, -100, 2000, 0, 255, 256, -256, -255, -2048, 255, 1023};
    localparam int V_CYC [NV] = '{40,  40,   40,   40, 4,   4,   4,    4,    40,    8,   12};
    localparam int V_UP  [NV] = '{0,   3,    0,    0,  0,   0,   1,    0,    10,    0,   0};
    localparam int V_DN  [NV] = '{10,  0,    10,   0,  0,   1,   0,    0,    0,     1,   3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [VEL_W-1:0] vel_in = '0;
    logic cnt_up;
    logic cnt_dn;

    int n_chk = 0;
    int n_err = 0;
    int kc = 0;
    bit done = 0;

    rate_count_vco u_rate_count_vco (
        .clk    (clk),
        .rst_n  (rst_n),
        .vel_in (vel_in),
        .cnt_up (cnt_up),
        .cnt_dn (cnt_dn)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        vel_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        kc = 0;
    endtask

    task automatic run(input int v, input int n, output int ups, output int dns,
                       output int misalign, output int both);
        ups = 0; dns = 0; misalign = 0; both = 0;
        vel_in = VEL_W'(v);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            kc++;
            if (cnt_up) ups++;
            if (cnt_dn) dns++;
            if ((cnt_up || cnt_dn) && (kc % DIV != 0)) misalign++;
            if (cnt_up && cnt_dn) both++;
        end
    endtask

    initial begin
        int u, d, m, b;
        // R1: reset held with full-scale input gives no pulses
        rst_n = 1'b0;
        vel_in = VEL_W'(2000);
        u = 0; d = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (cnt_up) u++;
            if (cnt_dn) d++;
        end
        chk("R1 pulses during reset", u + d, 0);

        // vector table: R2 R3 R4 R5 R6 R7 R8
        for (int t = 0; t < NV; t++) begin
            do_reset();
            run(V_VEL[t], V_CYC[t], u, d, m, b);
            chk($sformatf("R2/R4 up count vec %0d", t), u, V_UP[t]);
            chk($sformatf("R2/R3 dn count vec %0d", t), d, V_DN[t]);
            chk($sformatf("R5/R8 tick alignment vec %0d", t), m, 0);
            chk($sformatf("R6 both high vec %0d", t), b, 0);
        end

        // R9 and R7: saturated charge drains after the input drops to zero
        do_reset();
        run(2000, 8, u, d, m, b);
        chk("R7 capped dn count", d, 2);
        run(0, 16, u, d, m, b);
        chk("R9 leftover dn count", d, 3);
        chk("R9 no up pulses", u, 0);

        // R1: reset mid-run clears the accumulator
        do_reset();
        run(200, 3, u, d, m, b);
        do_reset();
        run(100, 8, u, d, m, b);
        chk("R1 accumulator cleared", u + d, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule